// File: doc/BRIEF.md
# PWM Timing Register Shadow and Reload Controller

This block keeps the timing set of one PWM channel group behind a shadow layer. The timing set is an initial count, a bank of compare values, a matching bank of fractional compare values and a prescaler select. Software writes reach only the buffer copies. The values the counter logic sees change only when a reload pulse arrives while the load-enable bit is armed. In that case every buffer is copied at once, so the counter never works from a half-written set.

Three status flags record what has happened. One shows that the buffers changed since the last real load. One shows that a reload pulse arrived while the buffers held a partial update and load-enable was not armed. One records that a reload pulse arrived at all. The block also drives one auxiliary output. During a fault or stop condition, a 2-bit code makes that output 0, 1 or high impedance. A forced level is set before the polarity inversion is applied.

With the default parameters (three compare channels), the word addresses are: initial count 0, compare values 1 to 3, fractional values 4 to 6, control 7, prescaler 8 and status 9.

Top module: `pwm_reload_ctrl`

## Requirements
- R1: A write to a data address (initial count 0, compare values 1–3, fractional values 4–6, prescaler 8) stores the value in that buffer. A read of that address returns it. The active outputs do not change.
- R2: Any write to a data address sets the updated flag, status bit 2, which software can only read.
- R3: A reload pulse while load-enable (control bit 0) is 1 copies every buffer to the active outputs on that clock edge and clears the updated flag.
- R4: The same reload clears load-enable, so control bit 0 reads 0 afterwards.
- R5: A reload pulse while load-enable is 0 leaves every active output unchanged.
- R6: A reload pulse with load-enable 0 and the updated flag 1 sets the reload error flag, status bit 1. With the updated flag 0, the error flag stays 0.
- R7: Writing 1 to status bit 1 clears the error flag. Writing 0 there has no effect.
- R8: Every reload pulse sets the reload flag, status bit 0. Writing 1 to status bit 0 clears it.
- R9: Reset clears all flags, load-enable, every buffer and every active value to zero.
- R10: Status bits 15 to 3 always read 0.
- R11: While fault_in is high, fault code (control bits 3:2) 00 gives a level of 0 and code 01 gives a level of 1. The level is then XORed with the polarity bit (control bit 1), and aux_oe stays 1.
- R12: While fault_in is high, fault codes 10 and 11 drive aux_oe to 0.
- R13: While fault_in is low, aux_oe is 1 and aux_out equals aux_in XOR polarity, in the same cycle that fault_in falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 16 | Read data for bus_addr |
| reload_in | input | 1 | Reload event pulse |
| fault_in | input | 1 | Fault or stop condition |
| aux_in | input | 1 | Normal auxiliary level |
| act_init | output | 16 | Active initial count |
| act_val | output | 48 | Active compare values, value i at bits [16i+15:16i] |
| act_frac | output | 15 | Active fractional values, value i at bits [5i+4:5i] |
| act_prsc | output | 3 | Active prescaler select |
| aux_out | output | 1 | Auxiliary output level |
| aux_oe | output | 1 | Auxiliary output drive enable |

## Verification
The clocked checks assume that reload_in and bus_we change only between clock edges. They also assume that fault_in and the control bits are stable around the sampling edge, because the auxiliary path is purely combinational. The stimulus drives every input on the falling edge. It reads the combinational outputs a short time after changing them. It never applies a control write and a reload pulse in the same cycle, so the load-enable checks only see the self-clear case.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;
  typedef enum logic [1:0] {
    FS_DRIVE_LO = 2'b00,
    FS_DRIVE_HI = 2'b01,
    FS_FLOAT_A  = 2'b10,
    FS_FLOAT_B  = 2'b11
  } fault_state_e;

  localparam int CTRL_ARM_BIT = 0;
  localparam int CTRL_POL_BIT = 1;
  localparam int CTRL_FS_LSB  = 2;

  localparam int STS_RLD_BIT = 0;
  localparam int STS_ERR_BIT = 1;
  localparam int STS_UPD_BIT = 2;
  localparam int STS_USED    = 3;
endpackage

// File: rtl/reload_shadow_regs.sv
module reload_shadow_regs #(
  parameter int CNT_W   = 16,
  parameter int NUM_VAL = 3,
  parameter int FRAC_W  = 5,
  parameter int PRSC_W  = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [CNT_W-1:0]                   wdata_i,
  input  logic                               wr_init_i,
  input  logic [NUM_VAL-1:0]                 wr_val_i,
  input  logic [NUM_VAL-1:0]                 wr_frac_i,
  input  logic                               wr_prsc_i,
  input  logic                               load_i,
  output logic [CNT_W-1:0]                   buf_init_o,
  output logic [NUM_VAL-1:0][CNT_W-1:0]      buf_val_o,
  output logic [NUM_VAL-1:0][FRAC_W-1:0]     buf_frac_o,
  output logic [PRSC_W-1:0]                  buf_prsc_o,
  output logic [CNT_W-1:0]                   act_init_o,
  output logic [NUM_VAL-1:0][CNT_W-1:0]      act_val_o,
  output logic [NUM_VAL-1:0][FRAC_W-1:0]     act_frac_o,
  output logic [PRSC_W-1:0]                  act_prsc_o
);
  logic [CNT_W-1:0]  init_d;
  logic [PRSC_W-1:0] prsc_d;

  always_comb begin
    init_d = wr_init_i ? wdata_i : buf_init_o;
    prsc_d = wr_prsc_i ? wdata_i[PRSC_W-1:0] : buf_prsc_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_init_o <= '0;
      buf_prsc_o <= '0;
      act_init_o <= '0;
      act_prsc_o <= '0;
    end else begin
      buf_init_o <= init_d;
      buf_prsc_o <= prsc_d;
      if (load_i) begin
        act_init_o <= buf_init_o;
        act_prsc_o <= buf_prsc_o;
      end
    end
  end

  for (genvar i = 0; i < NUM_VAL; i++) begin : g_chan
    logic [CNT_W-1:0]  val_d;
    logic [FRAC_W-1:0] frac_d;

    always_comb begin
      val_d  = wr_val_i[i]  ? wdata_i : buf_val_o[i];
      frac_d = wr_frac_i[i] ? wdata_i[FRAC_W-1:0] : buf_frac_o[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        buf_val_o[i]  <= '0;
        buf_frac_o[i] <= '0;
        act_val_o[i]  <= '0;
        act_frac_o[i] <= '0;
      end else begin
        buf_val_o[i]  <= val_d;
        buf_frac_o[i] <= frac_d;
        if (load_i) begin
          act_val_o[i]  <= buf_val_o[i];
          act_frac_o[i] <= buf_frac_o[i];
        end
      end
    end
  end

  // R3
  copy_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (act_init_o == $past(buf_init_o)) && (act_val_o == $past(buf_val_o)));

  // R5
  hold_without_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(act_init_o) && $stable(act_val_o) && $stable(act_frac_o) && $stable(act_prsc_o));
endmodule

// File: rtl/reload_status.sv
module reload_status (
  input  logic clk,
  input  logic rst_n,
  input  logic reload_i,
  input  logic data_wr_i,
  input  logic ctrl_wr_i,
  input  logic arm_wdata_i,
  input  logic sts_wr_i,
  input  logic clr_err_i,
  input  logic clr_rld_i,
  output logic arm_o,
  output logic upd_o,
  output logic err_o,
  output logic rld_o,
  output logic load_o
);
  logic arm_d, upd_d, err_d, rld_d;

  assign load_o = reload_i & arm_o;

  always_comb begin
    arm_d = arm_o;
    if (ctrl_wr_i)   arm_d = arm_wdata_i;
    else if (load_o) arm_d = 1'b0;

    upd_d = (upd_o & ~load_o) | data_wr_i;

    err_d = err_o;
    if (sts_wr_i && clr_err_i) err_d = 1'b0;
    if (reload_i && !arm_o && upd_o) err_d = 1'b1;

    rld_d = rld_o;
    if (sts_wr_i && clr_rld_i) rld_d = 1'b0;
    if (reload_i) rld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_o <= 1'b0;
      upd_o <= 1'b0;
      err_o <= 1'b0;
      rld_o <= 1'b0;
    end else begin
      arm_o <= arm_d;
      upd_o <= upd_d;
      err_o <= err_d;
      rld_o <= rld_d;
    end
  end

  // R2
  upd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_i |=> upd_o);

  // R4
  arm_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_i && arm_o && !ctrl_wr_i) |=> !arm_o);

  // R6
  err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_i && !arm_o && upd_o) |=> err_o);

  // R6
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_o && !(reload_i && upd_o)) |=> !err_o);

  // R8
  rld_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> rld_o);
endmodule

// File: rtl/aux_fault_mux.sv
module aux_fault_mux
  import pwm_reload_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fault_i,
  input  logic         aux_i,
  input  logic         pol_i,
  input  fault_state_e fs_i,
  output logic         out_o,
  output logic         oe_o
);
  logic pre_pol;

  always_comb begin
    pre_pol = aux_i;
    oe_o    = 1'b1;
    if (fault_i) begin
      unique case (fs_i)
        FS_DRIVE_LO: pre_pol = 1'b0;
        FS_DRIVE_HI: pre_pol = 1'b1;
        FS_FLOAT_A, FS_FLOAT_B: oe_o = 1'b0;
        default: oe_o = 1'b0;
      endcase
    end
    out_o = oe_o ? (pre_pol ^ pol_i) : 1'b0;
  end

  // R12
  float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_i && fs_i[1]) |-> !oe_o);

  // R13
  normal_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_i |-> (oe_o && (out_o == (aux_i ^ pol_i))));

  // R11
  forced_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_i && !fs_i[1]) |-> (oe_o && (out_o == (fs_i[0] ^ pol_i))));
endmodule

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl
  import pwm_reload_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_VAL = 3,
  parameter int FRAC_W  = 5,
  parameter int PRSC_W  = 3,
  parameter int ADDR_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [CNT_W-1:0]          bus_wdata,
  input  logic                      bus_we,
  output logic [CNT_W-1:0]          bus_rdata,
  input  logic                      reload_in,
  input  logic                      fault_in,
  input  logic                      aux_in,
  output logic [CNT_W-1:0]          act_init,
  output logic [NUM_VAL*CNT_W-1:0]  act_val,
  output logic [NUM_VAL*FRAC_W-1:0] act_frac,
  output logic [PRSC_W-1:0]         act_prsc,
  output logic                      aux_out,
  output logic                      aux_oe
);
  localparam int A_INIT = 0;
  localparam int A_VAL  = 1;
  localparam int A_FRAC = A_VAL + NUM_VAL;
  localparam int A_CTRL = A_FRAC + NUM_VAL;
  localparam int A_PRSC = A_CTRL + 1;
  localparam int A_STS  = A_CTRL + 2;

  logic [1:0] rst_sync;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  logic               wr_init, wr_prsc, wr_ctrl, wr_sts, data_wr;
  logic [NUM_VAL-1:0] wr_val, wr_frac;

  always_comb begin
    wr_init = bus_we && (int'(bus_addr) == A_INIT);
    wr_prsc = bus_we && (int'(bus_addr) == A_PRSC);
    wr_ctrl = bus_we && (int'(bus_addr) == A_CTRL);
    wr_sts  = bus_we && (int'(bus_addr) == A_STS);
    for (int i = 0; i < NUM_VAL; i++) begin
      wr_val[i]  = bus_we && (int'(bus_addr) == A_VAL + i);
      wr_frac[i] = bus_we && (int'(bus_addr) == A_FRAC + i);
    end
    data_wr = wr_init | wr_prsc | (|wr_val) | (|wr_frac);
  end

  logic         pol_q, pol_d;
  fault_state_e fs_q, fs_d;

  always_comb begin
    pol_d = pol_q;
    fs_d  = fs_q;
    if (wr_ctrl) begin
      pol_d = bus_wdata[CTRL_POL_BIT];
      fs_d  = fault_state_e'(bus_wdata[CTRL_FS_LSB +: 2]);
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      pol_q <= 1'b0;
      fs_q  <= FS_DRIVE_LO;
    end else begin
      pol_q <= pol_d;
      fs_q  <= fs_d;
    end
  end

  logic arm, upd, err, rld, load;

  reload_status u_status (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .reload_i   (reload_in),
    .data_wr_i  (data_wr),
    .ctrl_wr_i  (wr_ctrl),
    .arm_wdata_i(bus_wdata[CTRL_ARM_BIT]),
    .sts_wr_i   (wr_sts),
    .clr_err_i  (bus_wdata[STS_ERR_BIT]),
    .clr_rld_i  (bus_wdata[STS_RLD_BIT]),
    .arm_o      (arm),
    .upd_o      (upd),
    .err_o      (err),
    .rld_o      (rld),
    .load_o     (load)
  );

  logic [CNT_W-1:0]              buf_init;
  logic [NUM_VAL-1:0][CNT_W-1:0] buf_val;
  logic [NUM_VAL-1:0][FRAC_W-1:0] buf_frac;
  logic [PRSC_W-1:0]             buf_prsc;
  logic [NUM_VAL-1:0][CNT_W-1:0] act_val_a;
  logic [NUM_VAL-1:0][FRAC_W-1:0] act_frac_a;

  reload_shadow_regs #(
    .CNT_W(CNT_W), .NUM_VAL(NUM_VAL), .FRAC_W(FRAC_W), .PRSC_W(PRSC_W)
  ) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wdata_i   (bus_wdata),
    .wr_init_i (wr_init),
    .wr_val_i  (wr_val),
    .wr_frac_i (wr_frac),
    .wr_prsc_i (wr_prsc),
    .load_i    (load),
    .buf_init_o(buf_init),
    .buf_val_o (buf_val),
    .buf_frac_o(buf_frac),
    .buf_prsc_o(buf_prsc),
    .act_init_o(act_init),
    .act_val_o (act_val_a),
    .act_frac_o(act_frac_a),
    .act_prsc_o(act_prsc)
  );

  assign act_val  = act_val_a;
  assign act_frac = act_frac_a;

  aux_fault_mux u_aux (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .fault_i(fault_in),
    .aux_i  (aux_in),
    .pol_i  (pol_q),
    .fs_i   (fs_q),
    .out_o  (aux_out),
    .oe_o   (aux_oe)
  );

  always_comb begin
    bus_rdata = '0;
    if (int'(bus_addr) == A_INIT) bus_rdata = buf_init;
    if (int'(bus_addr) == A_PRSC) bus_rdata[PRSC_W-1:0] = buf_prsc;
    if (int'(bus_addr) == A_CTRL) begin
      bus_rdata[CTRL_ARM_BIT]       = arm;
      bus_rdata[CTRL_POL_BIT]       = pol_q;
      bus_rdata[CTRL_FS_LSB +: 2]   = fs_q;
    end
    if (int'(bus_addr) == A_STS) begin
      bus_rdata[STS_RLD_BIT] = rld;
      bus_rdata[STS_ERR_BIT] = err;
      bus_rdata[STS_UPD_BIT] = upd;
    end
    for (int i = 0; i < NUM_VAL; i++) begin
      if (int'(bus_addr) == A_VAL + i)  bus_rdata = buf_val[i];
      if (int'(bus_addr) == A_FRAC + i) bus_rdata = {{(CNT_W-FRAC_W){1'b0}}, buf_frac[i]};
    end
  end

  // R10
  sts_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (int'(bus_addr) == A_STS) |-> (bus_rdata[CNT_W-1:STS_USED] == '0));
endmodule

// File: tb/pwm_reload_ctrl_test.sv
module pwm_reload_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int NV = 3;
  localparam int FW = 5;
  localparam int A_CTRL = 7;
  localparam int A_PRSC = 8;
  localparam int A_STS  = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic [W-1:0]  bus_rdata;
  logic          reload_in = 1'b0;
  logic          fault_in = 1'b0;
  logic          aux_in = 1'b0;
  logic [W-1:0]  act_init;
  logic [NV*W-1:0]  act_val;
  logic [NV*FW-1:0] act_frac;
  logic [2:0]    act_prsc;
  logic          aux_out, aux_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_reload_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .reload_in(reload_in),
    .fault_in(fault_in), .aux_in(aux_in), .act_init(act_init),
    .act_val(act_val), .act_frac(act_frac), .act_prsc(act_prsc),
    .aux_out(aux_out), .aux_oe(aux_oe)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a[3:0]; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a[3:0];
    #1 d = bus_rdata;
  endtask

  task automatic pulse_reload();
    @(negedge clk);
    reload_in = 1'b1;
    @(negedge clk);
    reload_in = 1'b0;
  endtask

  task automatic t_reset();
    logic [W-1:0] d;
    rd(A_STS, d);   check("R9 status", d, 16'h0000);
    rd(A_CTRL, d);  check("R9 ctrl", d, 16'h0000);
    check("R9 act_init", act_init, 16'h0000);
    check("R9 act_val", act_val[W-1:0] | act_val[2*W-1:W] | act_val[3*W-1:2*W], 16'h0000);
    rd(0, d);       check("R9 buffer", d, 16'h0000);
  endtask

  task automatic t_buffer();
    logic [W-1:0] d;
    wr(0, 16'h1234);
    wr(1, 16'h0100); wr(2, 16'h0200); wr(3, 16'h0300);
    wr(4, 16'h0011); wr(5, 16'h000A); wr(6, 16'h001F);
    wr(A_PRSC, 16'h0005);
    rd(0, d); check("R1 init readback", d, 16'h1234);
    rd(2, d); check("R1 val1 readback", d, 16'h0200);
    rd(6, d); check("R1 frac2 readback", d, 16'h001F);
    rd(A_PRSC, d); check("R1 prsc readback", d, 16'h0005);
    check("R1 active unchanged", act_init, 16'h0000);
    rd(A_STS, d); check("R2 updated flag", d, 16'h0004);
  endtask

  task automatic t_reload_unarmed();
    logic [W-1:0] d;
    pulse_reload();
    rd(A_STS, d); check("R6 error set", d, 16'h0007);
    check("R5 act_init held", act_init, 16'h0000);
    check("R5 act_prsc held", {13'd0, act_prsc}, 16'h0000);
  endtask

  task automatic t_w1c();
    logic [W-1:0] d;
    wr(A_STS, 16'h0000);
    rd(A_STS, d); check("R7 write zero no effect", d, 16'h0007);
    wr(A_STS, 16'h0002);
    rd(A_STS, d); check("R7 error cleared", d, 16'h0005);
    wr(A_STS, 16'h0001);
    rd(A_STS, d); check("R8 reload flag cleared", d, 16'h0004);
  endtask

  task automatic t_reload_armed();
    logic [W-1:0] d;
    wr(A_CTRL, 16'h0001);
    rd(A_CTRL, d); check("R4 armed", d, 16'h0001);
    pulse_reload();
    check("R3 act_init", act_init, 16'h1234);
    check("R3 act_val0", act_val[W-1:0], 16'h0100);
    check("R3 act_val2", act_val[3*W-1:2*W], 16'h0300);
    check("R3 act_frac0", {11'd0, act_frac[FW-1:0]}, 16'h0011);
    check("R3 act_frac1", {11'd0, act_frac[2*FW-1:FW]}, 16'h000A);
    check("R3 act_prsc", {13'd0, act_prsc}, 16'h0005);
    rd(A_STS, d); check("R3 updated cleared R8 set", d, 16'h0001);
    rd(A_CTRL, d); check("R4 self-clear", d, 16'h0000);
  endtask

  task automatic t_clean_reload();
    logic [W-1:0] d;
    wr(A_STS, 16'h0001);
    pulse_reload();
    rd(A_STS, d); check("R6 no error when coherent", d, 16'h0001);
    wr(0, 16'h5555);
    pulse_reload();
    check("R5 act_init held after new write", act_init, 16'h1234);
    rd(0, d); check("R1 buffer kept", d, 16'h5555);
  endtask

  task automatic t_fault();
    aux_in = 1'b1;
    wr(A_CTRL, 16'h0000);
    @(negedge clk); fault_in = 1'b1; #1;
    check("R11 code00 pol0", {14'd0, aux_oe, aux_out}, 16'h0002);
    wr(A_CTRL, 16'h0004); #1;
    check("R11 code01 pol0", {14'd0, aux_oe, aux_out}, 16'h0003);
    wr(A_CTRL, 16'h0002); #1;
    check("R11 code00 pol1", {14'd0, aux_oe, aux_out}, 16'h0003);
    wr(A_CTRL, 16'h0006); #1;
    check("R11 code01 pol1", {14'd0, aux_oe, aux_out}, 16'h0002);
    wr(A_CTRL, 16'h000A); #1;
    check("R12 code10", {15'd0, aux_oe}, 16'h0000);
    wr(A_CTRL, 16'h000C); #1;
    check("R12 code11", {15'd0, aux_oe}, 16'h0000);
    wr(A_CTRL, 16'h000E);
    @(negedge clk); fault_in = 1'b0; #1;
    check("R13 resume pol1", {14'd0, aux_oe, aux_out}, 16'h0002);
    aux_in = 1'b0; #1;
    check("R13 follow aux_in", {14'd0, aux_oe, aux_out}, 16'h0003);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_buffer();
    t_reload_unarmed();
    t_w1c();
    t_reload_armed();
    t_clean_reload();
    t_fault();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule